// File: doc/BRIEF.md
# Configurable Asynchronous Serial Transmitter

This block turns one data byte per request into an asynchronous serial frame on a single line. A mode word picks the frame layout. The data can be seven or eight bits long. An extra bit after the data can carry either a parity bit or an addressing flag. The frame ends with one or two stop bits. Data always goes out least-significant bit first. Bit timing comes from a one-cycle bit-rate tick produced by an external divider, and every bit on the line lasts exactly one tick period.

A producer offers a byte with a valid/ready handshake. The block copies the mode word and the addressing flag at the same moment it accepts the byte, so later changes to those inputs do not affect a frame that has already started. Ready is also raised while the final stop bit is on the line. A waiting byte can therefore follow the previous frame with no idle time between them.

Top module: `async_frame_tx`

## Requirements
- R1: After reset, and whenever no frame is in progress, `tx_line` is 1, `tx_busy` is 0 and `in_ready` is 1.
- R2: A frame starts with one low start bit, followed by the data bits least-significant bit first. Each bit lasts from one `bit_tick` to the next, and the start bit appears in the cycle after the accepting tick.
- R3: With `mode_len7` = 1, only data bits 6..0 are sent and bit 7 has no effect on the line. With `mode_len7` = 0, all eight bits are sent.
- R4: With `mode_par_en` = 1 and `mode_mp_en` = 0, a parity bit follows the last data bit. `mode_par_odd` = 0 makes the count of ones in the sent data bits plus the parity bit even, and `mode_par_odd` = 1 makes that count odd.
- R5: After the data and any extra bit, the line carries high stop bits: one when `mode_stop2` = 0 and two when `mode_stop2` = 1.
- R6: With `mode_mp_en` = 1, the value of `mp_flag` is sent right after the last data bit, and no parity bit is sent, whatever `mode_par_en` and `mode_par_odd` are.
- R7: A byte is accepted only in a cycle where `in_valid`, `in_ready` and `bit_tick` are all 1. `in_ready` is 1 only when idle or while the final stop bit is on the line. `tx_busy` is 1 from the cycle after acceptance until the final stop bit ends.
- R8: A byte accepted on the tick that ends the final stop bit starts its start bit right away, with no idle bit between the two frames.
- R9: Changing the mode inputs or `mp_flag` after acceptance does not change the frame already in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bit_tick | input | 1 | One-cycle pulse that marks each bit period |
| in_data | input | 8 | Byte to send |
| in_valid | input | 1 | A byte is offered |
| in_ready | output | 1 | The block can accept a byte on the next tick |
| mode_len7 | input | 1 | 1 = 7 data bits, 0 = 8 data bits |
| mode_par_en | input | 1 | 1 = add a parity bit |
| mode_par_odd | input | 1 | 0 = even parity, 1 = odd parity |
| mode_stop2 | input | 1 | 0 = one stop bit, 1 = two stop bits |
| mode_mp_en | input | 1 | 1 = send `mp_flag` in place of parity |
| mp_flag | input | 1 | Addressing flag (1 = ID frame, 0 = data frame) |
| tx_line | output | 1 | Serial output, high when idle |
| tx_busy | output | 1 | A frame is on the line |

## Verification
Acceptance happens on a tick edge, and the start bit and `tx_busy` show up in the very next cycle. Each later bit changes only in the cycle after a tick. The bench's reference model therefore advances only on those same tick edges, using input values the bench drove half a cycle earlier. It then compares `tx_line`, `tx_busy` and `in_ready` at every falling edge, once all outputs have settled. The directed scenarios cover each mode: seven-bit frames with bit 7 set, both parity senses, two stop bits, addressing frames with parity also enabled, back-to-back frames, and a mode change in the middle of a frame. After these come random frames.

// File: rtl/aftx_pkg.sv
package aftx_pkg;
   typedef struct packed {
      logic len_short;
      logic par_en;
      logic par_odd;
      logic stop_two;
      logic mp_en;
   } aftx_mode_t;
endpackage

// File: rtl/aftx_frame_build.sv
module aftx_frame_build
   import aftx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int SHORT_W = 7,
   parameter int FRAME_W = DATA_W + 4,
   parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
   input  logic [DATA_W-1:0]  data,
   input  aftx_mode_t         mode,
   input  logic               flag,
   output logic [FRAME_W-1:0] frame,
   output logic [CNT_W-1:0]   nbits
);
   logic [DATA_W-1:0] keep;
   logic [DATA_W-1:0] sent;
   logic [CNT_W-1:0]  dlen;
   logic              extra_en;
   logic              extra_bit;
   logic              par_bit;

   // which data bits take part in the frame
   for (genvar g = 0; g < DATA_W; g++) begin : g_keep
      if (g < SHORT_W) begin : g_always
         assign keep[g] = 1'b1;
      end else begin : g_long_only
         assign keep[g] = ~mode.len_short;
      end
   end

   assign sent      = data & keep;
   assign dlen      = mode.len_short ? CNT_W'(SHORT_W) : CNT_W'(DATA_W);
   assign par_bit   = (^sent) ^ mode.par_odd;
   assign extra_en  = mode.mp_en | mode.par_en;
   assign extra_bit = mode.mp_en ? flag : par_bit;

   always_comb begin
      frame    = '1;
      frame[0] = 1'b0;
      for (int i = 0; i < DATA_W; i++) begin
         if (keep[i]) frame[1+i] = data[i];
      end
      if (extra_en) frame[dlen + CNT_W'(1)] = extra_bit;
      nbits = CNT_W'(1) + dlen + CNT_W'(extra_en) + (mode.stop_two ? CNT_W'(2) : CNT_W'(1));
   end
endmodule

// File: rtl/aftx_shifter.sv
module aftx_shifter #(
   parameter int FRAME_W = 12,
   parameter int CNT_W   = $clog2(FRAME_W + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               tick,
   input  logic               load,
   input  logic [FRAME_W-1:0] frame,
   input  logic [CNT_W-1:0]   nbits,
   output logic               line,
   output logic               busy,
   output logic               last
);
   logic [FRAME_W-1:0] sh_q;
   logic [CNT_W-1:0]   rem_q;
   logic               busy_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh_q   <= '1;
         rem_q  <= '0;
         busy_q <= 1'b0;
      end else if (tick) begin
         if (load) begin
            sh_q   <= frame;
            rem_q  <= nbits;
            busy_q <= 1'b1;
         end else if (busy_q) begin
            if (rem_q == CNT_W'(1)) begin
               sh_q   <= '1;
               rem_q  <= '0;
               busy_q <= 1'b0;
            end else begin
               sh_q  <= {1'b1, sh_q[FRAME_W-1:1]};
               rem_q <= rem_q - CNT_W'(1);
            end
         end
      end
   end

   assign line = busy_q ? sh_q[0] : 1'b1;
   assign busy = busy_q;
   assign last = busy_q && (rem_q == CNT_W'(1));
endmodule

// File: rtl/async_frame_tx.sv
module async_frame_tx
   import aftx_pkg::*;
#(
   parameter int DATA_W  = 8,
   parameter int SHORT_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bit_tick,
   input  logic [DATA_W-1:0] in_data,
   input  logic              in_valid,
   output logic              in_ready,
   input  logic              mode_len7,
   input  logic              mode_par_en,
   input  logic              mode_par_odd,
   input  logic              mode_stop2,
   input  logic              mode_mp_en,
   input  logic              mp_flag,
   output logic              tx_line,
   output logic              tx_busy
);
   localparam int FRAME_W = DATA_W + 4;
   localparam int CNT_W   = $clog2(FRAME_W + 1);

   if (SHORT_W < 1 || SHORT_W >= DATA_W) begin : g_bad_short
      $error("async_frame_tx: SHORT_W must lie in 1..DATA_W-1");
   end

   aftx_mode_t         mode;
   logic [FRAME_W-1:0] frame;
   logic [CNT_W-1:0]   nbits;
   logic               busy;
   logic               last;
   logic               accept;

   assign mode = '{len_short: mode_len7, par_en: mode_par_en, par_odd: mode_par_odd,
                   stop_two: mode_stop2, mp_en: mode_mp_en};

   aftx_frame_build #(.DATA_W(DATA_W), .SHORT_W(SHORT_W), .FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_build (
      .data (in_data),
      .mode (mode),
      .flag (mp_flag),
      .frame(frame),
      .nbits(nbits)
   );

   assign in_ready = !busy || last;
   assign accept   = in_valid && in_ready && bit_tick;

   aftx_shifter #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
      .clk  (clk),
      .rst_n(rst_n),
      .tick (bit_tick),
      .load (accept),
      .frame(frame),
      .nbits(nbits),
      .line (tx_line),
      .busy (busy),
      .last (last)
   );

   assign tx_busy = busy;
endmodule

// File: rtl/async_frame_tx_chk.sv
module async_frame_tx_chk (
   input logic clk,
   input logic rst_n,
   input logic bit_tick,
   input logic in_valid,
   input logic in_ready,
   input logic tx_line,
   input logic tx_busy
);
   assert_idle_high_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_busy |-> tx_line && in_ready);

   assert_start_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (in_valid && in_ready && bit_tick) |=> (!tx_line && tx_busy));

   assert_hold_bit_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!bit_tick && tx_busy) |=> $stable(tx_line) && tx_busy);

   assert_last_is_stop_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_busy && in_ready) |-> tx_line);

   assert_end_on_tick_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(tx_busy) |-> $past(bit_tick));
endmodule

bind async_frame_tx async_frame_tx_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .bit_tick(bit_tick),
   .in_valid(in_valid),
   .in_ready(in_ready),
   .tx_line (tx_line),
   .tx_busy (tx_busy)
);

// File: tb/test_async_frame_tx.sv
`timescale 1ns/1ps
module test_async_frame_tx;
   localparam int TICK_DIV = 4;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic bit_tick = 1'b0;
   logic [7:0] in_data = 8'h00;
   logic in_valid = 1'b0;
   logic in_ready;
   logic mode_len7 = 1'b0, mode_par_en = 1'b0, mode_par_odd = 1'b0;
   logic mode_stop2 = 1'b0, mode_mp_en = 1'b0, mp_flag = 1'b0;
   logic tx_line, tx_busy;

   int checks = 0;
   int failures = 0;
   string cur_req = "R1";

   always #2.5 clk = ~clk;

   async_frame_tx i_async_frame_tx (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick),
      .in_data(in_data), .in_valid(in_valid), .in_ready(in_ready),
      .mode_len7(mode_len7), .mode_par_en(mode_par_en), .mode_par_odd(mode_par_odd),
      .mode_stop2(mode_stop2), .mode_mp_en(mode_mp_en), .mp_flag(mp_flag),
      .tx_line(tx_line), .tx_busy(tx_busy)
   );

   // tick generator
   int tdiv = 0;
   always @(posedge clk) begin
      if (tdiv == TICK_DIV - 1) begin tdiv <= 0; bit_tick <= 1'b1; end
      else begin tdiv <= tdiv + 1; bit_tick <= 1'b0; end
   end

   // behavioural reference model
   bit m_line = 1'b1;
   bit m_busy = 1'b0;
   bit q[$];
   int acc_cnt = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_line = 1'b1; m_busy = 1'b0; q.delete();
      end else if (bit_tick) begin
         bit acc;
         acc = in_valid && (!m_busy || q.size() == 0);
         if (m_busy) begin
            if (q.size() > 0) m_line = q.pop_front();
            else begin m_busy = 1'b0; m_line = 1'b1; end
         end
         if (acc) begin
            int dl;
            bit p;
            dl = mode_len7 ? 7 : 8;
            p = mode_par_odd;
            for (int i = 0; i < dl; i++) begin q.push_back(in_data[i]); p ^= in_data[i]; end
            if (mode_mp_en) q.push_back(mp_flag);
            else if (mode_par_en) q.push_back(p);
            q.push_back(1'b1);
            if (mode_stop2) q.push_back(1'b1);
            m_line = 1'b0; m_busy = 1'b1;
            acc_cnt++;
         end
      end
   end

   task automatic chk(input string req, input string what, input int act, input int exp);
      checks++;
      if (act != exp) begin
         failures++;
         $display("FAIL %s %s: actual=%0d expected=%0d at %0t", req, what, act, exp, $time);
      end
   endtask

   always @(negedge clk) begin
      if (rst_n) begin
         chk(cur_req, "tx_line", tx_line, m_line);
         chk(cur_req, "tx_busy", tx_busy, m_busy);
         chk(cur_req, "in_ready", in_ready, (!m_busy || q.size() == 0));
      end
   end

   task automatic set_mode(input bit l7, input bit pe, input bit po, input bit s2, input bit mp, input bit fl);
      mode_len7 = l7; mode_par_en = pe; mode_par_odd = po;
      mode_stop2 = s2; mode_mp_en = mp; mp_flag = fl;
   endtask

   // offer a byte at a falling edge and hold it until the model accepts it
   task automatic send(input logic [7:0] d);
      int start_cnt;
      start_cnt = acc_cnt;
      in_data = d; in_valid = 1'b1;
      while (acc_cnt == start_cnt) @(negedge clk);
      in_valid = 1'b0;
   endtask

   task automatic drain();
      @(negedge clk);
      while (m_busy) @(negedge clk);
      repeat (6) @(negedge clk);
   endtask

   bit done = 1'b0;

   initial begin
      repeat (3) @(negedge clk);
      // R1 reset state
      chk("R1", "reset tx_line", tx_line, 1);
      chk("R1", "reset tx_busy", tx_busy, 0);
      chk("R1", "reset in_ready", in_ready, 1);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);

      cur_req = "R2"; set_mode(0,0,0,0,0,0); send(8'hA5); drain();
      cur_req = "R2"; send(8'h3C); drain();
      cur_req = "R3"; set_mode(1,0,0,0,0,0); send(8'hD5); drain();
      cur_req = "R3"; send(8'h55); drain();
      cur_req = "R4"; set_mode(0,1,0,0,0,0); send(8'h07); drain();
      cur_req = "R4"; set_mode(0,1,1,0,0,0); send(8'h07); drain();
      cur_req = "R4"; set_mode(1,1,1,1,0,0); send(8'h81); drain();
      cur_req = "R5"; set_mode(0,0,0,1,0,0); send(8'hFF); drain();
      cur_req = "R6"; set_mode(0,1,1,0,1,1); send(8'h42); drain();
      cur_req = "R6"; set_mode(1,1,0,1,1,0); send(8'hC3); drain();

      // R7: valid held while busy must wait for the final stop bit
      cur_req = "R7"; set_mode(0,1,0,0,0,0); send(8'h11);
      repeat (5) @(negedge clk);
      send(8'h22); drain();

      // R8: back-to-back frames with no gap
      cur_req = "R8"; set_mode(0,0,0,0,0,0);
      send(8'h01); send(8'h80); send(8'hF0); drain();

      // R9: mode changes mid-frame
      cur_req = "R9"; set_mode(0,1,1,1,0,0); send(8'h9A);
      repeat (9) @(negedge clk);
      set_mode(1,0,0,0,1,1);
      drain();

      cur_req = "R2";
      for (int n = 0; n < 40; n++) begin
         set_mode($urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1),
                  $urandom_range(0,1), $urandom_range(0,1), $urandom_range(0,1));
         send(8'($urandom_range(0,255)));
         if ($urandom_range(0,1) == 1) repeat ($urandom_range(1,20)) @(negedge clk);
      end
      drain();
      done = 1'b1;
   end

   initial begin
      int cyc;
      cyc = 0;
      while (!done && cyc < 150000) begin @(negedge clk); cyc++; end
      if (!done) begin
         failures++;
         checks++;
         $display("FAIL watchdog: actual=%0d expected=done", cyc);
      end
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule